// File: doc/BRIEF.md
# Bidirectional Bus Shift Register

This block is an eight-stage data register that sits between two 8-bit buses, called A and B. It can take a parallel word from either bus, shift in serial data one bit per shift-clock edge, turn a parallel word into a serial stream, or hold its contents by reloading each stage with its own value. The parallel data can be captured on a shift-clock edge or loaded transparently. Whatever the register holds is presented on the bus that currently acts as the output.

Each bus is modelled as three separate vectors: an input vector, an output data vector and an output-enable vector. There are no real tri-state pins. Four controls pick the operation:

- a bus enable for the A side,
- a clocked/transparent select,
- a direction select,
- a parallel/serial select.

The block runs on one system clock. A one-cycle strobe marks each rising edge of the shift clock. The last stage drives a serial output, so several registers can be chained into a longer one.

Top module: `bidir_bus_shreg`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, all stages clear to zero on that edge. Both output-enable vectors are all zeros for as long as `rst_n` is low.
- R2: Parallel mode (`par_sel`=1), clocked (`async_sel`=0), direction B-to-A (`a_to_b`=0): on a cycle with `shift_tick`=1, `b_in` is captured and appears on the outputs after that edge. On a cycle with `shift_tick`=0, the contents do not change.
- R3: Parallel mode with `a_to_b`=1 and `a_en`=1: `a_in` is captured under the same timing rule as R2.
- R4: Parallel mode with `async_sel`=1: the selected input bus is loaded on every `clk` cycle, whatever `shift_tick` is. The last loaded value stays when the mode is left.
- R5: Parallel mode with `a_to_b`=1 and `a_en`=0: `a_in` has no effect and the contents are held. This applies in both the clocked and the transparent case.
- R6: Serial mode (`par_sel`=0): `async_sel` has no effect, and a shift happens only on cycles with `shift_tick`=1. On a shift, `ser_in` enters bit 0 (the first stage) and each bit i moves to bit i+1. `ser_out` always equals bit 7 (the last stage).
- R7: Output enables, outside reset:
  - `b_oe` is all ones when `a_to_b`=1 and all zeros otherwise.
  - `a_oe` is all ones only when `a_to_b`=0 and `a_en`=1, and all zeros otherwise.
  - `a_out` and `b_out` both always carry the register contents.
- R8: Two registers chained through `ser_out`→`ser_in` act as one 16-bit serial register. After 16 shifts the first bit shifted in sits in bit 7 of the downstream register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_tick | input | 1 | One-cycle strobe marking a shift-clock rising edge |
| a_en | input | 1 | A-bus enable |
| async_sel | input | 1 | 1 = transparent parallel load, 0 = clocked |
| a_to_b | input | 1 | 1 = A is input and B is output; 0 = B is input and A is output |
| par_sel | input | 1 | 1 = parallel mode, 0 = serial mode |
| ser_in | input | 1 | Serial data into the first stage |
| a_in | input | 8 | A-bus input data |
| a_out | output | 8 | A-bus output data |
| a_oe | output | 8 | A-bus output enable |
| b_in | input | 8 | B-bus input data |
| b_out | output | 8 | B-bus output data |
| b_oe | output | 8 | B-bus output enable |
| ser_out | output | 1 | Last stage, used for chaining |

## Verification
The bench first walks through all sixteen combinations of the four controls, once with the strobe high and once with it low. This separates capture from hold and shows which bus is the source and which is driven. Random cycles then mix controls, strobes and bus data on two chained registers. This tells apart the clocked and transparent loads, and a recirculating hold from a true load. Directed sequences cover:

- a transparent load followed by leaving the mode, to confirm the value is kept;
- a disabled A-bus whose data must not reach the register;
- a 16-bit serial pattern through the chain;
- a reset in the middle of the run.

// File: rtl/bsr_pkg.sv
// Shared types for the bidirectional bus shift register.
package bsr_pkg;
    // Per-cycle operation chosen by the control decoder.
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD_A = 3'd1,
        OP_LOAD_B = 3'd2,
        OP_RECIRC = 3'd3,
        OP_SHIFT  = 3'd4
    } bsr_op_e;
endpackage

// File: rtl/bsr_ctrl.sv
// Control decoder: turns the four mode controls and the shift strobe into one
// operation per system-clock cycle, and decides which bus is driven.
// Assumes shift_tick is high for exactly one clk cycle per shift-clock edge.
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic    shift_tick,
    input  logic    a_en,
    input  logic    async_sel,
    input  logic    a_to_b,
    input  logic    par_sel,
    output bsr_op_e op,
    output logic    a_drive,
    output logic    b_drive
);
    logic par_fire;

    // A parallel transfer fires on every cycle when transparent, otherwise only on a strobe.
    assign par_fire = async_sel | shift_tick;

    // Select the register operation for this cycle.
    always_comb begin
        op = OP_HOLD;
        if (!par_sel) begin
            if (shift_tick) op = OP_SHIFT;
        end else if (par_fire) begin
            if (a_to_b) op = a_en ? OP_LOAD_A : OP_RECIRC;
            else        op = OP_LOAD_B;
        end
    end

    // Output side: B is driven when A is the input; A only when enabled.
    always_comb begin
        b_drive = a_to_b;
        a_drive = !a_to_b && a_en;
    end
endmodule

// File: rtl/bsr_stage.sv
// One register stage: reset, load from either bus, take the previous stage's
// bit on a shift, or reload itself. Reset is synchronous and active low.
module bsr_stage
    import bsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bsr_op_e op,
    input  logic    a_d,
    input  logic    b_d,
    input  logic    prev_d,
    output logic    q
);
    // Stage state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD_A: q <= a_d;
                OP_LOAD_B: q <= b_d;
                OP_SHIFT:  q <= prev_d;
                OP_RECIRC: q <= q;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/bsr_outdrv.sv
// Bus output stage: presents the register on both output data vectors and
// expands the drive decisions to per-bit enables, forced off during reset.
module bsr_outdrv #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic [W-1:0] q,
    input  logic         a_drive,
    input  logic         b_drive,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         ser_out
);
    // Data outputs always follow the stored word.
    always_comb begin
        a_out   = q;
        b_out   = q;
        ser_out = q[W-1];
    end

    // Enables per bit, held low while reset is asserted.
    always_comb begin
        a_oe = {W{rst_n & a_drive}};
        b_oe = {W{rst_n & b_drive}};
    end
endmodule

// File: rtl/bidir_bus_shreg.sv
// Bidirectional bus shift register top: W stages between buses A and B, with
// clocked or transparent parallel load, serial shift and recirculating hold.
// Assumes all controls are synchronous to clk.
module bidir_bus_shreg
    import bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_tick,
    input  logic         a_en,
    input  logic         async_sel,
    input  logic         a_to_b,
    input  logic         par_sel,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         ser_out
);
    bsr_op_e      op;
    logic         a_drive;
    logic         b_drive;
    logic [W-1:0] q;

    bsr_ctrl u_ctrl (
        .shift_tick (shift_tick),
        .a_en       (a_en),
        .async_sel  (async_sel),
        .a_to_b     (a_to_b),
        .par_sel    (par_sel),
        .op         (op),
        .a_drive    (a_drive),
        .b_drive    (b_drive)
    );

    // Stage chain: bit 0 takes the serial input, bit i takes bit i-1.
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic prev;
        if (i == 0) begin : g_first
            assign prev = ser_in;
        end else begin : g_next
            assign prev = q[i-1];
        end
        bsr_stage u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .a_d    (a_in[i]),
            .b_d    (b_in[i]),
            .prev_d (prev),
            .q      (q[i])
        );
    end

    bsr_outdrv #(.W(W)) u_out (
        .rst_n   (rst_n),
        .q       (q),
        .a_drive (a_drive),
        .b_drive (b_drive),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/bsr_checker.sv
// Port-level properties for the bidirectional bus shift register.
module bsr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_tick,
    input logic         a_en,
    input logic         async_sel,
    input logic         a_to_b,
    input logic         par_sel,
    input logic         ser_in,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         ser_out
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (b_out == '0)); // R1
    AST_RESET_OE_OFF: assert property (@(posedge clk) !rst_n |-> (a_oe == '0 && b_oe == '0)); // R1
    AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && !a_to_b && (async_sel || shift_tick)) |=> (b_out == $past(b_in))); // R2
    AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && a_to_b && a_en && (async_sel || shift_tick)) |=> (a_out == $past(a_in))); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_tick && !(par_sel && async_sel)) |=> $stable(b_out)); // R2
    AST_RECIRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && a_to_b && !a_en) |=> $stable(a_out)); // R5
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_sel && shift_tick) |=> (b_out == {$past(b_out[W-2:0]), $past(ser_in)})); // R6
    AST_SEROUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_sel && shift_tick) |=> (ser_out == $past(a_out[W-2]))); // R6
    AST_OE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == {W{a_to_b}}) && (a_oe == {W{!a_to_b && a_en}})); // R7
endmodule

bind bidir_bus_shreg bsr_checker #(.W(W)) u_chk (.*);

// File: tb/tb_bidir_bus_shreg.sv
module tb_bidir_bus_shreg;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n, tick, ae, asel, ab, ps, si;
    logic [W-1:0] a1, b1, a2, b2;
    logic [W-1:0] a_out1, a_oe1, b_out1, b_oe1, a_out2, a_oe2, b_out2, b_oe2;
    logic so1, so2;
    logic [W-1:0] m1, m2;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bidir_bus_shreg #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .shift_tick(tick), .a_en(ae), .async_sel(asel),
        .a_to_b(ab), .par_sel(ps), .ser_in(si), .a_in(a1), .a_out(a_out1), .a_oe(a_oe1),
        .b_in(b1), .b_out(b_out1), .b_oe(b_oe1), .ser_out(so1)
    );

    bidir_bus_shreg #(.W(W)) dut_hi (
        .clk(clk), .rst_n(rst_n), .shift_tick(tick), .a_en(ae), .async_sel(asel),
        .a_to_b(ab), .par_sel(ps), .ser_in(so1), .a_in(a2), .a_out(a_out2), .a_oe(a_oe2),
        .b_in(b2), .b_out(b_out2), .b_oe(b_oe2), .ser_out(so2)
    );

    // Expected next register value, written from the requirements.
    function automatic logic [W-1:0] nxt(logic [W-1:0] q, logic rn, logic tk, logic e,
                                         logic s, logic d, logic p, logic sin,
                                         logic [W-1:0] a, logic [W-1:0] b);
        if (!rn) return '0;
        if (!p) return tk ? {q[W-2:0], sin} : q;
        if (!(s || tk)) return q;
        if (d) return e ? a : q;
        return b;
    endfunction

    function automatic string tag_of(logic rn, logic s, logic d, logic e, logic p);
        if (!rn) return "R1";
        if (!p) return "R6";
        if (d && !e) return "R5";
        if (s) return "R4";
        if (d) return "R3";
        return "R2";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(logic rn, logic tk, logic e, logic s, logic d, logic p, logic sin,
                        logic [W-1:0] xa1, logic [W-1:0] xb1,
                        logic [W-1:0] xa2, logic [W-1:0] xb2);
        logic [W-1:0] e1, e2;
        string t;
        rst_n = rn; tick = tk; ae = e; asel = s; ab = d; ps = p; si = sin;
        a1 = xa1; b1 = xb1; a2 = xa2; b2 = xb2;
        e1 = nxt(m1, rn, tk, e, s, d, p, sin, xa1, xb1);
        e2 = nxt(m2, rn, tk, e, s, d, p, m1[W-1], xa2, xb2);
        t = tag_of(rn, s, d, e, p);
        @(posedge clk);
        @(negedge clk);
        m1 = e1;
        m2 = e2;
        check(t, b_out1, m1);
        check("R7", a_out1, m1);
        check("R6", {{(W-1){1'b0}}, so1}, {{(W-1){1'b0}}, m1[W-1]});
        check("R8", b_out2, m2);
        check(rn ? "R7" : "R1", b_oe1, {W{rn && d}});
        check(rn ? "R7" : "R1", a_oe1, {W{rn && !d && e}});
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        void'($urandom(32'd1234));
        m1 = '1; m2 = '1;
        rst_n = 0; tick = 0; ae = 0; asel = 0; ab = 0; ps = 0; si = 0;
        a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        @(negedge clk);
        // R1: reset clears both registers and disables both buses.
        step(0, 1, 1, 1, 0, 1, 1, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        step(0, 0, 1, 0, 1, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00);

        // Every control combination, with and without the strobe.
        for (int c = 0; c < 32; c++)
            step(1, c[4], c[3], c[2], c[1], c[0], c[1] ^ c[2],
                 8'h30 + 8'(c), 8'hC0 ^ 8'(c), 8'h5A ^ 8'(c), 8'hA5 + 8'(c));

        // R4: transparent load from B on non-strobe cycles, then leave mode and keep value.
        step(1, 0, 0, 1, 0, 1, 0, 8'h00, 8'h3C, 8'h00, 8'hE1);
        check("R4", b_out1, 8'h3C);
        step(1, 0, 0, 1, 0, 1, 0, 8'h00, 8'h96, 8'h00, 8'h69);
        check("R4", b_out1, 8'h96);
        step(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'h11, 8'h00, 8'h22);
        check("R4", b_out1, 8'h96);

        // R3: clocked load from enabled A.
        step(1, 1, 1, 0, 1, 1, 0, 8'h7E, 8'h00, 8'h81, 8'h00);
        check("R3", b_out1, 8'h7E);

        // R5: disabled A bus ignored, clocked and transparent.
        step(1, 1, 0, 0, 1, 1, 0, 8'h00, 8'hFF, 8'hFF, 8'h00);
        check("R5", b_out1, 8'h7E);
        step(1, 0, 0, 1, 1, 1, 0, 8'h00, 8'hFF, 8'hFF, 8'h00);
        check("R5", b_out1, 8'h7E);

        // R2: strobe-less cycle holds in clocked B load.
        step(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'h55, 8'h00, 8'h55);
        check("R2", b_out1, 8'h7E);

        // R8: 16-bit serial pattern through the chain, MSB first; async_sel set to show it is ignored (R6).
        pat = 16'hA5C3;
        for (int i = 0; i < 16; i++)
            step(1, 1, 1, 1, 0, 0, pat[15 - i], 8'hFF, 8'h00, 8'hFF, 8'h00);
        check("R8", {b_out2, b_out1} [15:8], pat[15:8]);
        check("R8", b_out1, pat[7:0]);
        check("R6", {{(W-1){1'b0}}, so2}, {{(W-1){1'b0}}, pat[15]});

        // Random stimulus with a mid-run reset.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step((n == 1500) ? 1'b0 : 1'b1, r[0], r[1], r[2], r[3], r[4], r[5],
                 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule